// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the bus-facing half of a small register-controlled peripheral that sits on a two-wire serial bus. It samples the clock and data lines with a fast system clock. Each line passes through a synchronizer and a majority-vote filter. The block then detects start and stop conditions, receives bytes MSB first and acknowledges them, and pulls the data line low only as an open-drain driver. The first byte after a start is a complete 8-bit device address. Its upper nibble is a fixed device-type code and its lower nibble must equal four strap pins. The byte carries no direction bit, because the transfer direction is decided later by the command layer.

Every byte after the address is handed to the command layer as a one-cycle strobe with a flag that marks the instruction byte. Frame markers report an accepted address and the end of a frame. The command layer asks for a read by holding the read-request level when the instruction byte's acknowledge clock ends. The block then shifts out the supplied byte and ignores the master's response. While the command layer reports a nonvolatile write in progress, the block withholds the address acknowledge, so a master can poll until the device is ready.

Top module: `tw_slave_front`

## Requirements
- R1: A fall of the data line while the clock line is high starts address reception. This also applies in the middle of a byte, where the partial byte is dropped and the bit count restarts.
- R2: A rise of the data line while the clock line is high returns the block to idle and releases the data line. A frame that had an accepted address, and is ended by a stop or by a new start, gives a one-cycle `frm_end` pulse. After reset the data line is released and no strobe is active.
- R3: The 8-bit first byte is accepted only if bits 7:4 equal 4'b0101 and bits 3:0 equal `strap_addr`. An accepted address is acknowledged by pulling the data line low through the ninth clock, and gives one `frm_start` pulse. Any other address gets no acknowledge, and the block ignores all bytes until the next start or stop.
- R4: While `nv_busy` is high at the end of the eighth address bit, a matching address is not acknowledged. Once `nv_busy` is low, the same address is acknowledged again.
- R5: Each byte received after the address is delivered MSB first on `rx_data` with a one-cycle `rx_valid`. `rx_is_cmd` is high for the first such byte (the instruction) and low for later ones.
- R6: The instruction byte and every following byte written by the master are acknowledged.
- R7: `sda_pull` changes only while the clock line is low.
- R8: A pulse on either line that lasts one system-clock cycle has no effect. A one-cycle clock pulse shifts no bit, and a one-cycle data dip while the clock is high is not taken as a start.
- R9: If `rd_mode` is high when the instruction byte's acknowledge clock ends, `rd_data` is driven MSB first, with each bit changing after a clock fall. After eight bits the line is released, and the master's ninth bit and any further clocks are ignored until a stop or start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | Pull-low enable for the open-drain data line |
| strap_addr | input | 4 | Device address strap pins (low address nibble) |
| nv_busy | input | 1 | Nonvolatile write in progress; suppresses address acknowledge |
| rd_mode | input | 1 | Command layer requests a read after the instruction byte |
| rd_data | input | 8 | Byte to send during a read |
| rx_valid | output | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | output | 8 | Last received byte |
| rx_is_cmd | output | 1 | Delivered byte is the instruction byte |
| frm_start | output | 1 | One-cycle pulse on address acceptance |
| frm_end | output | 1 | One-cycle pulse when an accepted frame ends |

## Verification
The start detector and the bit shifter can both act in the same system-clock cycle when a master issues a repeated start partway through a byte. The bench provokes this by breaking off the instruction byte after three bits and sending a new start and address. It then judges that the new address is acknowledged, that `frm_end` fires once, and that the next byte arrives whole and flagged as the instruction. The filter and the edge detector meet in the same way, when a one-cycle glitch coincides with a real data bit. This case is judged by the received byte value.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam int TW_BYTE_W  = 8;
   localparam int TW_TYPE_W  = 4;
   localparam int TW_STRAP_W = TW_BYTE_W - TW_TYPE_W;

   typedef enum logic [2:0] {
      TW_IDLE,
      TW_RX,
      TW_ACK,
      TW_TX,
      TW_HOLD
   } tw_state_t;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;
   logic                   clean_q;

   initial begin
      if (SYNC_STAGES < 2) $fatal(1, "tw_line_filter: SYNC_STAGES must be at least 2");
      if (FILT_LEN % 2 != 1) $fatal(1, "tw_line_filter: FILT_LEN must be odd");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN == 1) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clean_q <= 1'b1;
         else        clean_q <= synced;
      end
   end else begin : g_major
      localparam int HALF = FILT_LEN / 2;
      logic [FILT_LEN-1:0] win;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win     <= '1;
            clean_q <= 1'b1;
         end else begin
            win     <= {win[FILT_LEN-2:0], synced};
            clean_q <= ($countones(win) > HALF);
         end
      end
      AST_FILT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
         (clean_q != $past(clean_q)) |-> ($past(win[0]) == clean_q)); // R8
   end

   assign clean = clean_q;
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_p;
   assign scl_fall = ~scl_f & scl_p;
   assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
   assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/tw_frame_engine.sv
module tw_frame_engine import tw_pkg::*; #(
   parameter logic [TW_TYPE_W-1:0] TYPE_ID = 4'b0101
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_lvl,
   input  logic                  sda_lvl,
   input  logic                  scl_rise,
   input  logic                  scl_fall,
   input  logic                  start_ev,
   input  logic                  stop_ev,
   input  logic [TW_STRAP_W-1:0] strap,
   input  logic                  nv_busy,
   input  logic                  rd_mode,
   input  logic [TW_BYTE_W-1:0]  rd_data,
   output logic                  sda_pull,
   output logic                  rx_valid,
   output logic [TW_BYTE_W-1:0]  rx_data,
   output logic                  rx_is_cmd,
   output logic                  frm_start,
   output logic                  frm_end
);
   localparam int CNT_W = $clog2(TW_BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TW_BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TW_BYTE_W - 1);
   localparam logic [1:0] IDX_ADDR = 2'd0;
   localparam logic [1:0] IDX_CMD  = 2'd1;
   localparam logic [1:0] IDX_DATA = 2'd2;

   tw_state_t             state;
   logic [CNT_W-1:0]      cnt;
   logic [1:0]            idx;
   logic [TW_BYTE_W-1:0]  shreg, txsh, rx_data_q;
   logic                  pull_q, framed, rx_valid_q, rx_is_cmd_q, frm_start_q, frm_end_q;
   logic                  addr_hit, ack_ok;

   assign addr_hit = (shreg == {TYPE_ID, strap});
   assign ack_ok   = (idx == IDX_ADDR) ? (addr_hit && !nv_busy) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= TW_IDLE;
         cnt         <= '0;
         idx         <= IDX_ADDR;
         shreg       <= '0;
         txsh        <= '0;
         rx_data_q   <= '0;
         pull_q      <= 1'b0;
         framed      <= 1'b0;
         rx_valid_q  <= 1'b0;
         rx_is_cmd_q <= 1'b0;
         frm_start_q <= 1'b0;
         frm_end_q   <= 1'b0;
      end else begin
         rx_valid_q  <= 1'b0;
         frm_start_q <= 1'b0;
         frm_end_q   <= 1'b0;
         if (start_ev) begin
            state     <= TW_RX;
            cnt       <= '0;
            idx       <= IDX_ADDR;
            pull_q    <= 1'b0;
            frm_end_q <= framed;
            framed    <= 1'b0;
         end else if (stop_ev) begin
            state     <= TW_IDLE;
            pull_q    <= 1'b0;
            frm_end_q <= framed;
            framed    <= 1'b0;
         end else begin
            case (state)
               TW_RX: begin
                  if (scl_rise && cnt < CNT_FULL) begin
                     shreg <= {shreg[TW_BYTE_W-2:0], sda_lvl};
                     cnt   <= cnt + 1'b1;
                     if (cnt == CNT_LAST && idx != IDX_ADDR) begin
                        rx_valid_q  <= 1'b1;
                        rx_data_q   <= {shreg[TW_BYTE_W-2:0], sda_lvl};
                        rx_is_cmd_q <= (idx == IDX_CMD);
                     end
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     if (ack_ok) begin
                        pull_q <= 1'b1;
                        state  <= TW_ACK;
                        if (idx == IDX_ADDR) begin
                           frm_start_q <= 1'b1;
                           framed      <= 1'b1;
                        end
                     end else begin
                        state <= TW_HOLD;
                     end
                  end
               end
               TW_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (idx != IDX_DATA) idx <= idx + 2'd1;
                     if (idx == IDX_CMD && rd_mode) begin
                        state  <= TW_TX;
                        txsh   <= rd_data;
                        pull_q <= ~rd_data[TW_BYTE_W-1];
                     end else begin
                        state  <= TW_RX;
                        pull_q <= 1'b0;
                     end
                  end
               end
               TW_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == CNT_FULL) begin
                        pull_q <= 1'b0;
                        state  <= TW_HOLD;
                     end else begin
                        txsh   <= {txsh[TW_BYTE_W-2:0], 1'b0};
                        pull_q <= ~txsh[TW_BYTE_W-2];
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull  = pull_q;
   assign rx_valid  = rx_valid_q;
   assign rx_data   = rx_data_q;
   assign rx_is_cmd = rx_is_cmd_q;
   assign frm_start = frm_start_q;
   assign frm_end   = frm_end_q;

   AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_q != $past(pull_q)) |-> !scl_lvl); // R7
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !pull_q); // R2
   AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_valid_q, frm_start_q, frm_end_q})); // R5
   AST_RX_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_q |-> framed); // R3
endmodule

// File: rtl/tw_slave_front.sv
module tw_slave_front import tw_pkg::*; #(
   parameter logic [TW_TYPE_W-1:0] TYPE_ID     = 4'b0101,
   parameter int                   SYNC_STAGES = 2,
   parameter int                   FILT_LEN    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  sda_pull,
   input  logic [TW_STRAP_W-1:0] strap_addr,
   input  logic                  nv_busy,
   input  logic                  rd_mode,
   input  logic [TW_BYTE_W-1:0]  rd_data,
   output logic                  rx_valid,
   output logic [TW_BYTE_W-1:0]  rx_data,
   output logic                  rx_is_cmd,
   output logic                  frm_start,
   output logic                  frm_end
);
   localparam int N_LINES = 2;
   localparam int L_SDA   = 0;
   localparam int L_SCL   = 1;

   logic [N_LINES-1:0] raw_lines, clean_lines;
   logic scl_rise, scl_fall, start_ev, stop_ev;

   assign raw_lines = {scl_in, sda_in};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      tw_line_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .FILT_LEN   (FILT_LEN)
      ) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .raw  (raw_lines[g]),
         .clean(clean_lines[g])
      );
   end

   tw_bus_events u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_f   (clean_lines[L_SCL]),
      .sda_f   (clean_lines[L_SDA]),
      .scl_rise(scl_rise),
      .scl_fall(scl_fall),
      .start_ev(start_ev),
      .stop_ev (stop_ev)
   );

   tw_frame_engine #(.TYPE_ID(TYPE_ID)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_lvl  (clean_lines[L_SCL]),
      .sda_lvl  (clean_lines[L_SDA]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .strap    (strap_addr),
      .nv_busy  (nv_busy),
      .rd_mode  (rd_mode),
      .rd_data  (rd_data),
      .sda_pull (sda_pull),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .rx_is_cmd(rx_is_cmd),
      .frm_start(frm_start),
      .frm_end  (frm_end)
   );
endmodule

// File: tb/tw_slave_front_tb.sv
module tw_slave_front_tb;
   localparam int Q = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_drv = 1'b1, sda_drv = 1'b1;
   logic sda_pull, rx_valid, rx_is_cmd, frm_start, frm_end;
   logic [3:0] strap_addr = 4'hA;
   logic nv_busy = 1'b0, rd_mode = 1'b0;
   logic [7:0] rd_data = 8'h00, rx_data;
   wire sda_line = sda_drv & ~sda_pull;

   int total = 0, fails = 0;
   int rx_cnt = 0, fs_cnt = 0, fe_cnt = 0, r7_viol = 0;
   logic [7:0] last_rx = 8'h00;
   logic last_cmd = 1'b0, prev_pull = 1'b0;

   always #10 clk = ~clk;

   tw_slave_front u_dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
      .sda_pull(sda_pull), .strap_addr(strap_addr), .nv_busy(nv_busy),
      .rd_mode(rd_mode), .rd_data(rd_data), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_is_cmd(rx_is_cmd), .frm_start(frm_start),
      .frm_end(frm_end)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin rx_cnt++; last_rx = rx_data; last_cmd = rx_is_cmd; end
         if (frm_start) fs_cnt++;
         if (frm_end) fe_cnt++;
         if (sda_pull != prev_pull && scl_drv) r7_viol++;
      end
      prev_pull = sda_pull;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      sda_drv = 1'b1; wt(Q); scl_drv = 1'b1; wt(Q);
      sda_drv = 1'b0; wt(Q); scl_drv = 1'b0; wt(Q);
   endtask

   task automatic do_stop();
      sda_drv = 1'b0; wt(Q); scl_drv = 1'b1; wt(Q);
      sda_drv = 1'b1; wt(2 * Q);
   endtask

   // kind: 0 plain, 1 one-cycle clock pulse while low, 2 one-cycle data dip while high
   task automatic put_bit(input logic b, input int kind);
      sda_drv = b;
      if (kind == 1) begin
         wt(Q / 2); scl_drv = 1'b1; wt(1); scl_drv = 1'b0; wt(Q / 2 - 1);
      end else wt(Q);
      scl_drv = 1'b1;
      if (kind == 2) begin
         wt(Q); sda_drv = 1'b0; wt(1); sda_drv = b; wt(Q - 1);
      end else wt(2 * Q);
      scl_drv = 1'b0; wt(Q);
   endtask

   task automatic nine_clk(input logic drive, output logic seen);
      sda_drv = drive; wt(Q); scl_drv = 1'b1; wt(Q);
      seen = sda_line; wt(Q); scl_drv = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input int gl_bit, input int gl_kind, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) put_bit(b[i], (i == gl_bit) ? gl_kind : 0);
      nine_clk(1'b1, s);
      ack = ~s;
   endtask

   task automatic read_byte(output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         nine_clk(1'b1, s);
         v[i] = s;
      end
   endtask

   // {address byte, nv_busy, expected acknowledge}
   localparam logic [9:0] VEC [6] = '{
      {8'h5A, 1'b0, 1'b1},
      {8'h5B, 1'b0, 1'b0},
      {8'h4A, 1'b0, 1'b0},
      {8'h5A, 1'b1, 1'b0},
      {8'hDA, 1'b0, 1'b0},
      {8'h5A, 1'b0, 1'b1}
   };

   initial begin
      repeat (150000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic a, a2, s;
      logic [7:0] v;
      int rx0, fs0, fe0;

      wt(5); rst_n = 1'b1; wt(10);
      chk(sda_pull == 1'b0 && rx_valid == 1'b0, "R2 reset release", int'(sda_pull), 0);
      chk(fs_cnt == 0 && fe_cnt == 0, "R2 reset no markers", fs_cnt + fe_cnt, 0);

      // R3 R4: address table
      for (int k = 0; k < 6; k++) begin
         nv_busy = VEC[k][1];
         rx0 = rx_cnt; fs0 = fs_cnt; fe0 = fe_cnt;
         do_start();
         send_byte(VEC[k][9:2], -1, 0, a);
         nv_busy = 1'b0;
         chk(a == VEC[k][0], "R3/R4 address acknowledge", int'(a), int'(VEC[k][0]));
         send_byte(8'h55, -1, 0, a2);
         chk(a2 == VEC[k][0], "R3 follow-on byte acknowledge", int'(a2), int'(VEC[k][0]));
         chk(rx_cnt - rx0 == int'(VEC[k][0]), "R3 byte delivery", rx_cnt - rx0, int'(VEC[k][0]));
         do_stop();
         chk(fs_cnt - fs0 == int'(VEC[k][0]) && fe_cnt - fe0 == int'(VEC[k][0]),
             "R2 frame markers", (fs_cnt - fs0) * 16 + (fe_cnt - fe0), int'(VEC[k][0]) * 17);
      end

      // R5 R6: write frame
      rx0 = rx_cnt; fe0 = fe_cnt;
      do_start();
      send_byte(8'h5A, -1, 0, a);
      send_byte(8'hA3, -1, 0, a);
      chk(a, "R6 instruction acknowledge", int'(a), 1);
      chk(last_rx == 8'hA3 && last_cmd, "R5 instruction byte", int'({last_cmd, last_rx}), 'h1A3);
      send_byte(8'h3C, -1, 0, a);
      chk(a, "R6 data acknowledge", int'(a), 1);
      chk(last_rx == 8'h3C && !last_cmd, "R5 data byte", int'({last_cmd, last_rx}), 'h03C);
      send_byte(8'hE1, -1, 0, a);
      chk(a && last_rx == 8'hE1, "R6 second data byte", int'({a, last_rx}), 'h1E1);
      do_stop();
      chk(fe_cnt - fe0 == 1 && sda_pull == 1'b0, "R2 stop ends frame", fe_cnt - fe0, 1);

      // R9: read frame
      rd_mode = 1'b1; rd_data = 8'h96;
      rx0 = rx_cnt;
      do_start();
      send_byte(8'h5A, -1, 0, a);
      send_byte(8'h9B, -1, 0, a);
      chk(a && last_cmd && last_rx == 8'h9B, "R9 read instruction taken", int'(last_rx), 'h9B);
      rd_mode = 1'b0;
      read_byte(v);
      chk(v == 8'h96, "R9 read data", int'(v), 'h96);
      nine_clk(1'b0, s);
      read_byte(v);
      chk(v == 8'hFF && rx_cnt - rx0 == 1, "R9 ignored after read", int'(v), 'hFF);
      do_stop();

      // R1: repeated start in mid-byte
      fe0 = fe_cnt;
      do_start();
      send_byte(8'h5A, -1, 0, a);
      put_bit(1'b1, 0); put_bit(1'b0, 0); put_bit(1'b1, 0);
      do_start();
      chk(fe_cnt - fe0 == 1, "R1 restart ends frame", fe_cnt - fe0, 1);
      send_byte(8'h5A, -1, 0, a);
      chk(a, "R1 address after restart", int'(a), 1);
      send_byte(8'h11, -1, 0, a);
      chk(last_rx == 8'h11 && last_cmd, "R1 byte after restart", int'({last_cmd, last_rx}), 'h111);
      do_stop();

      // R8: glitches on clock and data
      rx0 = rx_cnt;
      do_start();
      send_byte(8'h5A, 5, 1, a);
      chk(a, "R8 address with clock glitch", int'(a), 1);
      send_byte(8'hC5, 2, 2, a);
      chk(a && last_rx == 8'hC5 && rx_cnt - rx0 == 1, "R8 byte with data dip", int'(last_rx), 'hC5);
      send_byte(8'h6E, 4, 1, a);
      chk(a && last_rx == 8'h6E, "R8 byte with clock pulse", int'(last_rx), 'h6E);
      do_stop();

      chk(r7_viol == 0, "R7 pull changes with clock low", r7_viol, 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule